// File: doc/BRIEF.md
# Stack and Memory Access Sequencer

This block runs the memory side of stack-style operations for a simple 32-bit processor core. It holds eight general registers, one of which acts as the stack pointer and one as the frame pointer, and it holds the program counter. A command names an operation together with its operands. The block turns that command into a fixed sequence of byte transfers on a byte-wide memory port and then updates its registers. The operations are push, pop, call, return, frame teardown (leave), word load, word store, effective-address load and register set.

Memory addresses come from a displacement added to an optional base register and an optional index register. The index is scaled by 1, 2, 4 or 8, and the sum wraps modulo 2^32. Every 32-bit word is moved as four single-byte cycles on consecutive addresses, least significant byte first. The caller may issue a command only while `busy` is low. `done` marks the cycle in which the register results become visible. Any register and the program counter can be read back at any time.

Top module: `stack_seq`

## Requirements
- R1: After reset, `busy` and `done` are low, all eight registers read zero, and `pc_out` reads the reset PC (zero by default).
- R2: Load-address (op 1) writes disp + (base if enabled) + (index << scale, if enabled) to the named register, wrapping modulo 2^32. It makes no memory cycle, and `done` rises one cycle after acceptance.
- R3: Load (op 2) and store (op 3) move one word at the effective address A in exactly four consecutive byte cycles on addresses A, A+1, A+2, A+3, carrying bits 7:0 first and bits 31:24 last. The address may be unaligned.
- R4: Push (op 4) writes the named register to the word at SP−4 and then leaves SP−4 in SP. SP is register 4.
- R5: Pop (op 5) reads the word at SP into the named register and then adds 4 to SP. When the named register is SP itself, SP ends up as the loaded word plus 4.
- R6: Call (op 6) writes the fall-through PC to the word at SP−4, sets SP to SP−4 and sets the PC to the immediate target.
- R7: Return (op 7) loads the PC from the word at SP and adds 4 to SP.
- R8: Leave (op 8) loads the frame pointer (register 5) from the word at the old frame pointer and sets SP to the old frame pointer plus 4.
- R9: A command is taken only while `busy` is low, and a command offered while `busy` is high has no effect. `done` is a single-cycle pulse that coincides with the fall of `busy`. Register and PC updates are visible when `done` is high and never change while `busy` stays high.
- R10: Register set (op 0) writes the immediate to the named register. Every operation other than call and return sets the PC to the fall-through PC. Op codes 9 to 15 pulse `done`, touch no register and leave the PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Operation code |
| cmd_reg | input | 3 | Destination or source register |
| cmd_base_en | input | 1 | Base register takes part in the address |
| cmd_base | input | 3 | Base register |
| cmd_idx_en | input | 1 | Index register takes part in the address |
| cmd_idx | input | 3 | Index register |
| cmd_scale | input | 2 | Index shift amount, 0 to 3 |
| cmd_disp | input | 32 | Address displacement |
| cmd_imm | input | 32 | Immediate value or call target |
| cmd_next_pc | input | 32 | Fall-through PC |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Command finished, results visible |
| mem_en | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, captured at the clock edge |
| rd_sel | input | 3 | Register readback select |
| rd_data | output | 32 | Selected register value |
| pc_out | output | 32 | Program counter |

## Verification
Address computation is tried with base only, base plus scaled index at every scale, and a displacement that wraps past 2^32, so that a wrong shift or a dropped term gives a different sum. Words with four distinct bytes are stored, loaded at an unaligned address and pushed, which exposes byte order and address stepping. Push, pop, call and return are run as matched pairs so that the stack pointer must return to its start. Pop into the stack pointer itself and leave with a distinct saved frame value tell apart the orderings of the register write and the pointer update. A command offered in mid-sequence and an unused op code show that nothing changes at the ports.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int NREGS  = 8,
  parameter int BYTES  = 4,
  parameter int SP_IDX = 4,
  parameter int FP_IDX = 5,
  parameter logic [8*BYTES-1:0] RESET_PC = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [3:0]              cmd_op,
  input  logic [$clog2(NREGS)-1:0] cmd_reg,
  input  logic                    cmd_base_en,
  input  logic [$clog2(NREGS)-1:0] cmd_base,
  input  logic                    cmd_idx_en,
  input  logic [$clog2(NREGS)-1:0] cmd_idx,
  input  logic [1:0]              cmd_scale,
  input  logic [8*BYTES-1:0]      cmd_disp,
  input  logic [8*BYTES-1:0]      cmd_imm,
  input  logic [8*BYTES-1:0]      cmd_next_pc,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [8*BYTES-1:0]      mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  input  logic [$clog2(NREGS)-1:0] rd_sel,
  output logic [8*BYTES-1:0]      rd_data,
  output logic [8*BYTES-1:0]      pc_out
);
  localparam int DW = 8 * BYTES;
  localparam int RW = $clog2(NREGS);
  localparam int CW = $clog2(BYTES);
  localparam logic [DW-1:0] STEP = DW'(BYTES);
  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  localparam logic [3:0] OP_SET   = 4'd0;
  localparam logic [3:0] OP_ADDR  = 4'd1;
  localparam logic [3:0] OP_LOAD  = 4'd2;
  localparam logic [3:0] OP_STORE = 4'd3;
  localparam logic [3:0] OP_PUSH  = 4'd4;
  localparam logic [3:0] OP_POP   = 4'd5;
  localparam logic [3:0] OP_CALL  = 4'd6;
  localparam logic [3:0] OP_RET   = 4'd7;
  localparam logic [3:0] OP_LEAVE = 4'd8;

  logic [DW-1:0] regs [NREGS];
  logic [DW-1:0] pc_q;
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] addr_q, wbuf_q, tgt_q, npc_q;
  logic [DW-9:0] rbuf_q;
  logic [3:0]    op_q;
  logic [RW-1:0] dst_q;

  logic [DW-1:0] sp, fp, base_v, idx_v, ea, start_addr, start_data, word;
  logic          needs_mem, accept, writes_mem;

  assign sp     = regs[SP_IDX];
  assign fp     = regs[FP_IDX];
  assign base_v = cmd_base_en ? regs[cmd_base] : '0;
  assign idx_v  = cmd_idx_en ? (regs[cmd_idx] << cmd_scale) : '0;
  assign ea     = cmd_disp + base_v + idx_v;
  assign accept = cmd_valid && !busy_q;
  assign word   = {mem_rdata, rbuf_q};

  always_comb begin
    needs_mem  = 1'b1;
    start_addr = ea;
    start_data = regs[cmd_reg];
    case (cmd_op)
      OP_LOAD, OP_STORE: ;
      OP_PUSH:  start_addr = sp - STEP;
      OP_CALL: begin
        start_addr = sp - STEP;
        start_data = cmd_next_pc;
      end
      OP_POP, OP_RET: start_addr = sp;
      OP_LEAVE: start_addr = fp;
      default:  needs_mem = 1'b0;
    endcase
  end

  assign writes_mem = (op_q == OP_STORE) || (op_q == OP_PUSH) || (op_q == OP_CALL);

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_en    = busy_q;
  assign mem_we    = busy_q && writes_mem;
  assign mem_addr  = addr_q;
  assign mem_wdata = wbuf_q[8*cnt_q +: 8];
  assign rd_data   = regs[rd_sel];
  assign pc_out    = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREGS; k++) regs[k] <= '0;
      pc_q   <= RESET_PC;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      tgt_q  <= '0;
      npc_q  <= '0;
      op_q   <= OP_SET;
      dst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (needs_mem) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          addr_q <= start_addr;
          wbuf_q <= start_data;
          op_q   <= cmd_op;
          dst_q  <= cmd_reg;
          tgt_q  <= cmd_imm;
          npc_q  <= cmd_next_pc;
        end else begin
          done_q <= 1'b1;
          case (cmd_op)
            OP_SET: begin
              regs[cmd_reg] <= cmd_imm;
              pc_q <= cmd_next_pc;
            end
            OP_ADDR: begin
              regs[cmd_reg] <= ea;
              pc_q <= cmd_next_pc;
            end
            default: ;
          endcase
        end
      end else if (busy_q) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q != LAST) rbuf_q[8*cnt_q +: 8] <= mem_rdata;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pc_q   <= npc_q;
          case (op_q)
            OP_LOAD: regs[dst_q] <= word;
            OP_PUSH: regs[SP_IDX] <= sp - STEP;
            OP_POP: begin
              if (dst_q != RW'(SP_IDX)) regs[dst_q] <= word;
              regs[SP_IDX] <= ((dst_q == RW'(SP_IDX)) ? word : sp) + STEP;
            end
            OP_CALL: begin
              regs[SP_IDX] <= sp - STEP;
              pc_q <= tgt_q;
            end
            OP_RET: begin
              regs[SP_IDX] <= sp + STEP;
              pc_q <= word;
            end
            OP_LEAVE: begin
              regs[FP_IDX] <= word;
              regs[SP_IDX] <= fp + STEP;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int BYTES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               mem_en,
  input logic [8*BYTES-1:0] mem_addr,
  input logic [8*BYTES-1:0] pc_out
);
  int run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else     run <= mem_en ? run + 1 : 0;
  end

  AST_DONE_APART: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R9
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pc_out)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R3
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (run < BYTES)); // R3
endmodule

bind stack_seq stack_seq_chk #(.BYTES(BYTES)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_en(mem_en), .mem_addr(mem_addr), .pc_out(pc_out)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_reg = '0, cmd_base = '0, cmd_idx = '0, rd_sel = '0;
  logic        cmd_base_en = 1'b0, cmd_idx_en = 1'b0;
  logic [1:0]  cmd_scale = '0;
  logic [31:0] cmd_disp = '0, cmd_imm = '0, cmd_next_pc = '0;
  logic        busy, done, mem_en, mem_we;
  logic [31:0] mem_addr, rd_data, pc_out;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #4 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .cmd_base_en(cmd_base_en), .cmd_base(cmd_base), .cmd_idx_en(cmd_idx_en),
    .cmd_idx(cmd_idx), .cmd_scale(cmd_scale), .cmd_disp(cmd_disp), .cmd_imm(cmd_imm),
    .cmd_next_pc(cmd_next_pc), .busy(busy), .done(done), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .pc_out(pc_out)
  );

  typedef struct {
    string       tag;
    int          r;
    logic [31:0] rv, sp, pc, a0;
    int          nmem;
  } item_t;

  item_t       exp_q[$];
  logic [7:0]  bmem [int unsigned];
  logic [31:0] mr [8];
  logic [31:0] mpc;
  int nchk = 0, nerr = 0, nmem = 0;
  logic [31:0] first_a, last_a;
  bit seq_bad = 0;

  function automatic logic [7:0] rb(logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rw(logic [31:0] a);
    return {rb(a + 3), rb(a + 2), rb(a + 1), rb(a)};
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (nmem == 0) first_a = mem_addr;
      else if (mem_addr != last_a + 1) seq_bad = 1;
      last_a = mem_addr;
      nmem++;
      if (mem_we) bmem[mem_addr] = mem_wdata;
    end
  end
  always @(negedge clk) mem_rdata <= rb(mem_addr);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      item_t it;
      if (exp_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        it = exp_q.pop_front();
        rd_sel = 3'(it.r); #1;
        chk(rd_data == it.rv, {it.tag, " reg"}, rd_data, it.rv);
        rd_sel = 3'd4; #1;
        chk(rd_data == it.sp, {it.tag, " sp"}, rd_data, it.sp);
        chk(pc_out == it.pc, {it.tag, " pc"}, pc_out, it.pc);
        chk(nmem == it.nmem, {it.tag, " byte cycles"}, nmem, it.nmem);
        if (it.nmem > 0) begin
          chk(first_a == it.a0, {it.tag, " first addr"}, first_a, it.a0);
          chk(!seq_bad, {it.tag, " addr step"}, {31'd0, seq_bad}, 0);
        end
      end
      nmem = 0;
      seq_bad = 0;
    end
  end

  task automatic issue(string tag, logic [3:0] op, int r, bit be, int b, bit ie, int ix,
                       int sc, logic [31:0] disp, logic [31:0] imm, logic [31:0] npc,
                       bit poke = 0);
    item_t it;
    logic [31:0] ea, v, old;
    ea = disp + (be ? mr[b] : 32'd0) + (ie ? (mr[ix] << sc) : 32'd0);
    it.tag = tag; it.r = r; it.nmem = 4; it.a0 = 0;
    case (op)
      0: begin mr[r] = imm; mpc = npc; it.nmem = 0; end
      1: begin mr[r] = ea; mpc = npc; it.nmem = 0; end
      2: begin it.a0 = ea; mr[r] = rw(ea); mpc = npc; end
      3: begin it.a0 = ea; mpc = npc; end
      4: begin it.a0 = mr[4] - 4; mr[4] = mr[4] - 4; mpc = npc; end
      5: begin it.a0 = mr[4]; v = rw(mr[4]); mr[r] = v; mr[4] = mr[4] + 4; mpc = npc; end
      6: begin it.a0 = mr[4] - 4; mr[4] = mr[4] - 4; mpc = imm; end
      7: begin it.a0 = mr[4]; mpc = rw(mr[4]); mr[4] = mr[4] + 4; end
      8: begin it.a0 = mr[5]; old = mr[5]; mr[5] = rw(old); mr[4] = old + 4; mpc = npc; end
      default: it.nmem = 0;
    endcase
    it.rv = mr[r]; it.sp = mr[4]; it.pc = mpc;
    exp_q.push_back(it);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_op = op; cmd_reg = 3'(r); cmd_base_en = be; cmd_base = 3'(b);
    cmd_idx_en = ie; cmd_idx = 3'(ix); cmd_scale = 2'(sc);
    cmd_disp = disp; cmd_imm = imm; cmd_next_pc = npc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      cmd_op = 4'd0; cmd_reg = 3'd3; cmd_imm = 32'hDEAD_BEEF; cmd_valid = 1'b1;
      @(negedge clk); @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic check_reg(int r, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_sel = 3'(r); #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    for (int k = 0; k < 8; k++) mr[k] = 0;
    mpc = 0;
    bmem[32'h401] = 8'hA1; bmem[32'h402] = 8'hB2;
    bmem[32'h403] = 8'hC3; bmem[32'h404] = 8'hD4;
    bmem[32'h2000] = 8'h10; bmem[32'h2001] = 8'h00;
    bmem[32'h2002] = 8'hCD; bmem[32'h2003] = 8'hAB;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", {31'd0, busy}, 0);
    chk(done == 0, "R1 done", {31'd0, done}, 0);
    chk(pc_out == 0, "R1 pc", pc_out, 0);
    for (int k = 0; k < 8; k++) check_reg(k, 32'd0, "R1 reg");

    issue("R10 set r0", 0, 0, 0, 0, 0, 0, 0, 0, 32'h20, 32'h4);
    issue("R10 set r1", 0, 1, 0, 0, 0, 0, 0, 0, 32'h11223344, 32'h8);
    issue("R10 set r2", 0, 2, 0, 0, 0, 0, 0, 0, 32'h3, 32'hC);
    issue("R10 set r3", 0, 3, 0, 0, 0, 0, 0, 0, 32'h55, 32'h10);
    issue("R10 set sp", 0, 4, 0, 0, 0, 0, 0, 0, 32'h1000, 32'h14);
    issue("R10 set fp", 0, 5, 0, 0, 0, 0, 0, 0, 32'h2000, 32'h18);

    issue("R2 base", 1, 6, 1, 0, 0, 0, 0, 32'h100, 0, 32'h20);
    for (int s = 0; s < 4; s++)
      issue("R2 scaled", 1, 6, 1, 0, 1, 2, s, 32'h7, 0, 32'h24);
    issue("R2 wrap", 1, 7, 1, 0, 0, 0, 0, 32'hFFFF_FFF0, 0, 32'h28);

    issue("R3 store", 3, 1, 1, 0, 0, 0, 0, 32'h2E0, 0, 32'h30);
    chk(bmem[32'h300] == 8'h44, "R3 byte0", {24'd0, bmem[32'h300]}, 32'h44);
    chk(bmem[32'h303] == 8'h11, "R3 byte3", {24'd0, bmem[32'h303]}, 32'h11);
    issue("R3 unaligned load", 2, 6, 0, 0, 0, 0, 0, 32'h401, 0, 32'h34);

    issue("R4 push", 4, 1, 0, 0, 0, 0, 0, 0, 0, 32'h38);
    chk(rw(32'hFFC) == 32'h11223344, "R4 stacked word", rw(32'hFFC), 32'h11223344);
    issue("R5 pop", 5, 7, 0, 0, 0, 0, 0, 0, 0, 32'h3C);
    issue("R6 call", 6, 0, 0, 0, 0, 0, 0, 0, 32'h5000, 32'h123);
    chk(rw(32'hFFC) == 32'h123, "R6 return addr", rw(32'hFFC), 32'h123);
    issue("R7 ret", 7, 0, 0, 0, 0, 0, 0, 0, 0, 32'h5004);
    issue("R8 leave", 8, 5, 0, 0, 0, 0, 0, 0, 0, 32'h128);

    issue("R9 load during poke", 2, 6, 0, 0, 0, 0, 0, 32'h300, 0, 32'h12C, 1);
    check_reg(3, 32'h55, "R9 ignored command");
    issue("R10 unknown op", 4'd12, 3, 0, 0, 0, 0, 0, 0, 32'h999, 32'h777);

    issue("R4 push r3", 4, 3, 0, 0, 0, 0, 0, 0, 0, 32'h130);
    issue("R5 pop into sp", 5, 4, 0, 0, 0, 0, 0, 0, 0, 32'h134);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 pending results", exp_q.size(), 0);
    report();
  end
endmodule